// File: doc/BRIEF.md
# Boundary-Scan Data Register for a Dual Line Interface

This block is the boundary-scan data register that sits between the core logic and the digital pads of a two-channel line interface device. A separate TAP controller drives it. That controller supplies three strobes (capture, shift and update) and two decoded instruction lines. One line selects sampling/preloading. The other selects external test, in which the register drives the pads. Test data enters serially at `tdi` and leaves at `tdo`.

Every pad has a kind. An input pad owns one cell bit. An output pad owns two bits: an enable and a data value. A bidirectional pad owns three bits: an enable, an output value and a captured pad value. A pad of kind "none" owns no cell at all, which fits analog, supply or clock pins that stay out of the scan path. The cells are concatenated in physical pin order. Pin 0 sits at the `tdo` end, so its cell is the first to leave the chain.

Each cell has two stages: a shift stage clocked on the rising edge of `tck`, and a hold latch loaded on the falling edge. Because of this split, data moving through the chain never reaches the pads. Outside external test, the core's own output and enable signals pass straight through to the pads.

Top module: `bsr_chain`

## Requirements
- R1: With the default pin map, the serial path from `tdi` to `tdo` is exactly 67 bits long. A vector shifted in fully and then followed by 67 further bits comes out unchanged and in the same order.
- R2: Pin kind codes are 0 = no cell, 1 = input (1 bit), 2 = output (2 bits), 3 = bidirectional (3 bits). Pin 0's cell starts at chain bit 0, which is the bit nearest `tdo`. Each later pin starts where the previous one ends. Within a cell, the lowest bit is the enable (the first bit shifted in for that pin), the next bit is the output data, and for a bidirectional pin the third bit is the captured pad value. For an input pin, its single bit is the captured pad value. The default map has 33 pins: bidirectional at 0, 8, 9, 11 to 18, 20, 26 and 27; output at 1, 2, 5, 6, 21, 22 and 23; no cell at 28; input everywhere else.
- R3: On a rising `tck` edge with `capture_dr` high and the chain selected, each enable bit loads `core_oe`, each output-data bit loads `core_out`, and each captured-pad bit loads `pad_in`.
- R4: On a rising `tck` edge with `shift_dr` high, `capture_dr` low and the chain selected, every bit moves one place toward `tdo` and `tdi` enters the far end. `tdo` always shows chain bit 0.
- R5: On a falling `tck` edge with `update_dr` high and the chain selected, the hold latch copies the shift stage. At no other time does the hold latch change.
- R6: While `sel_extest` is high, each output or bidirectional pad drives `pad_oe` from its held enable bit and `pad_out` from its held data bit.
- R7: While `sel_extest` is low, each output or bidirectional pad passes `core_out` and `core_oe` through unchanged.
- R8: An input-kind pad always presents `pad_oe` = 0 and `pad_out` = 0.
- R9: A pad with no cell passes `core_out` and `core_oe` through under every instruction.
- R10: When neither `sel_sample` nor `sel_extest` is high, the capture, shift and update strobes have no effect on the shift stage or the hold latch.
- R11: A low `trst_n` clears the shift stage and the hold latch at once, without waiting for a clock edge.
- R12: Under external test, shifting or capturing without an update leaves every scanned pad's `pad_out` and `pad_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| sel_sample | input | 1 | Decoded sample/preload instruction |
| sel_extest | input | 1 | Decoded external-test instruction |
| tdo | output | 1 | Serial test data out (chain bit 0) |
| pad_in | input | NUM_PINS | Values seen at the pads |
| core_out | input | NUM_PINS | Functional output data from the core |
| core_oe | input | NUM_PINS | Functional output enables from the core |
| pad_out | output | NUM_PINS | Data driven toward the pads |
| pad_oe | output | NUM_PINS | Output enables toward the pads |

## Verification
The hardest behaviour to reach from the ports is the isolation between the two stages. Under external test, the pads must keep their held values while a completely different vector passes through the shift stage. Unselected strobes must also leave both stages alone. To reach this, the stimulus first preloads a vector under sample/preload and updates it. It then switches to external test and shifts in the bitwise complement, checking the pads before the next update. Finally, it deselects the chain, fires every strobe, and reads back both stages through the pads and `tdo`.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int MAX_PINS = 64;

    typedef enum logic [1:0] {
        PK_NONE  = 2'd0,
        PK_IN    = 2'd1,
        PK_OUT   = 2'd2,
        PK_BIDIR = 2'd3
    } pin_kind_e;

    typedef logic [2*MAX_PINS-1:0] kind_map_t;
    typedef logic [MAX_PINS-1:0]   pin_mask_t;

    function automatic pin_kind_e kind_at(kind_map_t map, int idx);
        return pin_kind_e'(map[2*idx +: 2]);
    endfunction

    function automatic int cell_bits(pin_kind_e kind);
        case (kind)
            PK_IN:    return 1;
            PK_OUT:   return 2;
            PK_BIDIR: return 3;
            default:  return 0;
        endcase
    endfunction

    // bit position of the first cell bit of pin idx (pin 0 nearest TDO)
    function automatic int cell_offset(kind_map_t map, int idx);
        int acc;
        acc = 0;
        for (int i = 0; i < MAX_PINS; i++) begin
            if (i < idx) acc += cell_bits(kind_at(map, i));
        end
        return acc;
    endfunction

    function automatic int chain_length(kind_map_t map, int pins);
        return cell_offset(map, pins);
    endfunction

    function automatic pin_mask_t kind_mask(kind_map_t map, int pins, pin_kind_e kind);
        pin_mask_t m;
        m = '0;
        for (int i = 0; i < MAX_PINS; i++) begin
            if (i < pins && kind_at(map, i) == kind) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic pin_kind_e default_kind(int idx);
        case (idx)
            0, 8, 9, 11, 12, 13, 14, 15, 16, 17, 18, 20, 26, 27: return PK_BIDIR;
            1, 2, 5, 6, 21, 22, 23:                             return PK_OUT;
            28:                                                 return PK_NONE;
            default:                                            return PK_IN;
        endcase
    endfunction

    localparam int DEFAULT_PINS = 33;

    function automatic kind_map_t build_default_map();
        kind_map_t m;
        m = '0;
        for (int i = 0; i < DEFAULT_PINS; i++) m[2*i +: 2] = default_kind(i);
        return m;
    endfunction

    localparam kind_map_t DEFAULT_MAP = build_default_map();

endpackage

// File: rtl/bsr_capture_map.sv
module bsr_capture_map #(
    parameter int                 NUM_PINS = bsr_pkg::DEFAULT_PINS,
    parameter bsr_pkg::kind_map_t KIND_MAP = bsr_pkg::DEFAULT_MAP,
    parameter int                 LEN      = bsr_pkg::chain_length(KIND_MAP, NUM_PINS)
) (
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    output logic [LEN-1:0]      cap_vec
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam bsr_pkg::pin_kind_e KIND = bsr_pkg::kind_at(KIND_MAP, g);
        localparam int                 OFF  = bsr_pkg::cell_offset(KIND_MAP, g);

        if (KIND == bsr_pkg::PK_IN) begin : g_in
            assign cap_vec[OFF] = pad_in[g];
        end else if (KIND == bsr_pkg::PK_OUT) begin : g_out
            assign cap_vec[OFF]   = core_oe[g];
            assign cap_vec[OFF+1] = core_out[g];
        end else if (KIND == bsr_pkg::PK_BIDIR) begin : g_bidir
            assign cap_vec[OFF]   = core_oe[g];
            assign cap_vec[OFF+1] = core_out[g];
            assign cap_vec[OFF+2] = pad_in[g];
        end
    end

endmodule

// File: rtl/bsr_shift_stage.sv
module bsr_shift_stage #(
    parameter int LEN = 67
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           sel,
    input  logic           capture,
    input  logic           shift,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] chain_q,
    output logic           tdo
);

    typedef struct packed {
        logic [LEN-1:0] bits;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (capture) begin
                st_d.bits = cap_vec;
            end else if (shift) begin
                st_d.bits = {tdi, st_q.bits[LEN-1:1]};
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign chain_q = st_q.bits;
    assign tdo     = st_q.bits[0];

endmodule

// File: rtl/bsr_hold_latch.sv
module bsr_hold_latch #(
    parameter int LEN = 67
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           sel,
    input  logic           update,
    input  logic [LEN-1:0] chain_q,
    output logic [LEN-1:0] hold_q
);

    typedef struct packed {
        logic [LEN-1:0] bits;
    } hold_st_t;

    hold_st_t hl_d, hl_q;

    always_comb begin
        hl_d = hl_q;
        if (sel && update) hl_d.bits = chain_q;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) hl_q <= '0;
        else         hl_q <= hl_d;
    end

    assign hold_q = hl_q.bits;

endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux #(
    parameter int                 NUM_PINS = bsr_pkg::DEFAULT_PINS,
    parameter bsr_pkg::kind_map_t KIND_MAP = bsr_pkg::DEFAULT_MAP,
    parameter int                 LEN      = bsr_pkg::chain_length(KIND_MAP, NUM_PINS)
) (
    input  logic                extest,
    input  logic [LEN-1:0]      hold_q,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam bsr_pkg::pin_kind_e KIND = bsr_pkg::kind_at(KIND_MAP, g);
        localparam int                 OFF  = bsr_pkg::cell_offset(KIND_MAP, g);

        if (KIND == bsr_pkg::PK_IN) begin : g_in
            // input pads never drive
            assign pad_out[g] = 1'b0;
            assign pad_oe[g]  = 1'b0;
        end else if (KIND == bsr_pkg::PK_NONE) begin : g_none
            assign pad_out[g] = core_out[g];
            assign pad_oe[g]  = core_oe[g];
        end else begin : g_drv
            always_comb begin
                if (extest) begin
                    pad_oe[g]  = hold_q[OFF];
                    pad_out[g] = hold_q[OFF+1];
                end else begin
                    pad_oe[g]  = core_oe[g];
                    pad_out[g] = core_out[g];
                end
            end
        end
    end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
    parameter int                 NUM_PINS = bsr_pkg::DEFAULT_PINS,
    parameter bsr_pkg::kind_map_t KIND_MAP = bsr_pkg::DEFAULT_MAP
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tdi,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                sel_sample,
    input  logic                sel_extest,
    output logic                tdo,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    localparam int CHAIN_LEN = bsr_pkg::chain_length(KIND_MAP, NUM_PINS);

    logic                 chain_sel;
    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] chain_q;
    logic [CHAIN_LEN-1:0] hold_q;

    assign chain_sel = sel_sample | sel_extest;

    bsr_capture_map #(
        .NUM_PINS (NUM_PINS),
        .KIND_MAP (KIND_MAP),
        .LEN      (CHAIN_LEN)
    ) u_capture (
        .pad_in   (pad_in),
        .core_out (core_out),
        .core_oe  (core_oe),
        .cap_vec  (cap_vec)
    );

    bsr_shift_stage #(
        .LEN (CHAIN_LEN)
    ) u_shift (
        .tck     (tck),
        .trst_n  (trst_n),
        .sel     (chain_sel),
        .capture (capture_dr),
        .shift   (shift_dr),
        .tdi     (tdi),
        .cap_vec (cap_vec),
        .chain_q (chain_q),
        .tdo     (tdo)
    );

    bsr_hold_latch #(
        .LEN (CHAIN_LEN)
    ) u_hold (
        .tck     (tck),
        .trst_n  (trst_n),
        .sel     (chain_sel),
        .update  (update_dr),
        .chain_q (chain_q),
        .hold_q  (hold_q)
    );

    bsr_pad_mux #(
        .NUM_PINS (NUM_PINS),
        .KIND_MAP (KIND_MAP),
        .LEN      (CHAIN_LEN)
    ) u_pads (
        .extest   (sel_extest),
        .hold_q   (hold_q),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

endmodule

// File: rtl/bsr_chain_checker.sv
module bsr_chain_checker #(
    parameter int                 NUM_PINS = bsr_pkg::DEFAULT_PINS,
    parameter bsr_pkg::kind_map_t KIND_MAP = bsr_pkg::DEFAULT_MAP,
    parameter int                 LEN      = bsr_pkg::chain_length(KIND_MAP, NUM_PINS)
) (
    input logic                tck,
    input logic                trst_n,
    input logic                tdi,
    input logic                capture_dr,
    input logic                shift_dr,
    input logic                update_dr,
    input logic                sel_sample,
    input logic                sel_extest,
    input logic [LEN-1:0]      cap_vec,
    input logic [LEN-1:0]      chain_q,
    input logic [LEN-1:0]      hold_q,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);

    localparam bsr_pkg::pin_mask_t IN_FULL   = bsr_pkg::kind_mask(KIND_MAP, NUM_PINS, bsr_pkg::PK_IN);
    localparam bsr_pkg::pin_mask_t NONE_FULL = bsr_pkg::kind_mask(KIND_MAP, NUM_PINS, bsr_pkg::PK_NONE);
    localparam logic [NUM_PINS-1:0] IN_MASK   = IN_FULL[NUM_PINS-1:0];
    localparam logic [NUM_PINS-1:0] SCAN_MASK = ~NONE_FULL[NUM_PINS-1:0];

    logic sel_any;
    logic past_valid;

    assign sel_any = sel_sample | sel_extest;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) past_valid <= 1'b0;
        else         past_valid <= 1'b1;
    end

    AST_CAPTURE_LOADS: assert property (@(posedge tck) disable iff (!trst_n)
        (sel_any && capture_dr) |=> (chain_q == $past(cap_vec))) else $error("capture"); // R3

    AST_SHIFT_ADVANCES: assert property (@(posedge tck) disable iff (!trst_n)
        (sel_any && shift_dr && !capture_dr) |=>
            (chain_q[LEN-2:0] == $past(chain_q[LEN-1:1]) && chain_q[LEN-1] == $past(tdi))) else $error("shift"); // R4

    AST_HOLD_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        (past_valid && !(sel_any && update_dr)) |-> $stable(hold_q)) else $error("hold"); // R5

    AST_INPUT_NEVER_DRIVES: assert property (@(posedge tck) disable iff (!trst_n)
        (pad_oe & IN_MASK) == '0) else $error("input oe"); // R8

    AST_UNSELECTED_FROZEN: assert property (@(posedge tck) disable iff (!trst_n)
        (past_valid && !sel_any) |=> $stable(chain_q)) else $error("unselected"); // R10

    AST_PADS_STILL_DURING_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        (past_valid && sel_extest && $past(sel_extest) && !update_dr) |->
            ($stable(pad_out & SCAN_MASK) && $stable(pad_oe & SCAN_MASK))) else $error("pads moved"); // R12

endmodule

bind bsr_chain bsr_chain_checker #(
    .NUM_PINS (NUM_PINS),
    .KIND_MAP (KIND_MAP),
    .LEN      (CHAIN_LEN)
) i_bsr_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tdi        (tdi),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .sel_sample (sel_sample),
    .sel_extest (sel_extest),
    .cap_vec    (cap_vec),
    .chain_q    (chain_q),
    .hold_q     (hold_q),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/test_bsr_chain.sv
module test_bsr_chain;

    localparam int NP = 33;
    localparam int L  = 67;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tdi = 1'b0;
    logic          capture_dr = 1'b0;
    logic          shift_dr = 1'b0;
    logic          update_dr = 1'b0;
    logic          sel_sample = 1'b0;
    logic          sel_extest = 1'b0;
    logic          tdo;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] core_out = '0;
    logic [NP-1:0] core_oe = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int checks = 0;
    int errors = 0;
    int offs [NP];
    int kinds [NP];

    always #2.5 tck = ~tck;

    bsr_chain i_bsr_chain (
        .tck, .trst_n, .tdi, .capture_dr, .shift_dr, .update_dr,
        .sel_sample, .sel_extest, .tdo, .pad_in, .core_out, .core_oe,
        .pad_out, .pad_oe
    );

    // pin kinds per R2: 0 none, 1 input, 2 output, 3 bidirectional
    function automatic int spec_kind(int p);
        case (p)
            0, 8, 9, 11, 12, 13, 14, 15, 16, 17, 18, 20, 26, 27: return 3;
            1, 2, 5, 6, 21, 22, 23:                             return 2;
            28:                                                 return 0;
            default:                                            return 1;
        endcase
    endfunction

    function automatic logic [L-1:0] exp_cap(logic [NP-1:0] pi, logic [NP-1:0] co, logic [NP-1:0] ce);
        logic [L-1:0] r;
        r = '0;
        for (int p = 0; p < NP; p++) begin
            if (kinds[p] == 1) r[offs[p]] = pi[p];
            if (kinds[p] >= 2) begin
                r[offs[p]]   = ce[p];
                r[offs[p]+1] = co[p];
            end
            if (kinds[p] == 3) r[offs[p]+2] = pi[p];
        end
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_out(logic ext, logic [L-1:0] h, logic [NP-1:0] co);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            if (kinds[p] == 1)      r[p] = 1'b0;
            else if (kinds[p] == 0) r[p] = co[p];
            else                    r[p] = ext ? h[offs[p]+1] : co[p];
        end
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_oe(logic ext, logic [L-1:0] h, logic [NP-1:0] ce);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            if (kinds[p] == 1)      r[p] = 1'b0;
            else if (kinds[p] == 0) r[p] = ce[p];
            else                    r[p] = ext ? h[offs[p]] : ce[p];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge tck);
        #1;
    endtask

    task automatic shift_vec(input logic [L-1:0] vin, output logic [L-1:0] vout);
        shift_dr = 1'b1;
        for (int i = 0; i < L; i++) begin
            vout[i] = tdo;
            tdi = vin[i];
            cyc();
        end
        shift_dr = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        cyc();
        capture_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        cyc();
        update_dr = 1'b0;
    endtask

    task automatic check_pads(input string tag, input logic ext, input logic [L-1:0] h);
        check({tag, " pad_out"}, 128'(pad_out), 128'(exp_out(ext, h, core_out)));
        check({tag, " pad_oe"},  128'(pad_oe),  128'(exp_oe(ext, h, core_oe)));
    endtask

    task automatic t_reset();
        core_out = 33'h1_5A3C_96E1;
        core_oe  = 33'h0_F0F0_3C5A;
        trst_n = 1'b0;
        repeat (3) cyc();
        trst_n = 1'b1;
        cyc();
        check("R11 tdo after reset", 128'(tdo), 128'(0));
        check_pads("R7 R8 R9 functional pass", 1'b0, '0);
        sel_extest = 1'b1;
        #1;
        check_pads("R11 cleared hold drives", 1'b1, '0);
        sel_extest = 1'b0;
        cyc();
    endtask

    task automatic t_sample(input logic [NP-1:0] pi, input logic [NP-1:0] co, input logic [NP-1:0] ce);
        logic [L-1:0] got;
        pad_in = pi; core_out = co; core_oe = ce;
        sel_sample = 1'b1;
        cyc();
        do_capture();
        shift_vec('0, got);
        check("R3 R2 captured chain", 128'(got), 128'(exp_cap(pi, co, ce)));
        sel_sample = 1'b0;
        cyc();
    endtask

    task automatic t_length();
        logic [L-1:0] a, b, got;
        a = 67'h5_1C3A_9F02_E6D4_B785;
        b = 67'h2_E0F1_0B7C_44A9_3D16;
        sel_sample = 1'b1;
        cyc();
        shift_vec(a, got);
        shift_vec(b, got);
        check("R1 R4 chain length and order", 128'(got), 128'(a));
        shift_vec('0, got);
        check("R4 second vector", 128'(got), 128'(b));
        sel_sample = 1'b0;
        cyc();
    endtask

    task automatic t_extest();
        logic [L-1:0] p, got;
        p = 67'h3_A5C3_0FF1_7E96_D21B;
        core_out = 33'h0_3333_CCCC;
        core_oe  = 33'h1_FFFF_0000;
        sel_sample = 1'b1;
        cyc();
        shift_vec(p, got);
        do_update();
        check_pads("R7 preload not driven", 1'b0, p);
        sel_sample = 1'b0;
        sel_extest = 1'b1;
        cyc();
        check_pads("R6 R8 R9 extest drives hold", 1'b1, p);
        shift_vec(~p, got);
        check_pads("R12 pads still after shift", 1'b1, p);
        do_capture();
        check_pads("R12 pads still after capture", 1'b1, p);
        shift_vec(~p, got);
        do_update();
        check_pads("R5 update loads new hold", 1'b1, ~p);
        core_out = ~core_out;
        core_oe  = ~core_oe;
        #1;
        check_pads("R9 unscanned pad follows core", 1'b1, ~p);
        sel_extest = 1'b0;
        cyc();
    endtask

    task automatic t_unselected();
        logic [L-1:0] v, junk, got;
        v = 67'h1_0F1E_2D3C_4B5A_6978;
        sel_sample = 1'b1;
        cyc();
        shift_vec(v, got);
        do_update();
        sel_sample = 1'b0;
        cyc();
        pad_in = 33'h1_FFFF_FFFF;
        core_out = 33'h0_1234_5678;
        core_oe  = 33'h1_8765_4321;
        do_capture();
        shift_vec(~v, junk);
        do_update();
        sel_extest = 1'b1;
        #1;
        check_pads("R10 hold kept when unselected", 1'b1, v);
        sel_extest = 1'b0;
        sel_sample = 1'b1;
        cyc();
        shift_vec('0, got);
        check("R10 shift stage kept when unselected", 128'(got), 128'(v));
        sel_sample = 1'b0;
        cyc();
    endtask

    task automatic t_async_reset();
        logic [L-1:0] v, got;
        v = 67'h7_FFFF_FFFF_FFFF_FFFF;
        sel_extest = 1'b1;
        cyc();
        shift_vec(v, got);
        do_update();
        check_pads("R6 all ones held", 1'b1, v);
        #1;
        trst_n = 1'b0;
        #0.5;
        check_pads("R11 async clear of hold", 1'b1, '0);
        check("R11 async clear of tdo", 128'(tdo), 128'(0));
        cyc();
        trst_n = 1'b1;
        sel_extest = 1'b0;
        cyc();
    endtask

    initial begin
        int acc;
        acc = 0;
        for (int p = 0; p < NP; p++) begin
            kinds[p] = spec_kind(p);
            offs[p]  = acc;
            acc += (kinds[p] == 3) ? 3 : kinds[p];
        end
        t_reset();
        t_sample(33'h1_A5A5_5A5A, 33'h0_C3C3_3C3C, 33'h1_0FF0_F00F);
        t_sample(33'h0_5A5A_A5A5, 33'h1_3C3C_C3C3, 33'h0_F00F_0FF0);
        t_length();
        t_extest();
        t_unselected();
        t_async_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge tck);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule